// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a free-running calendar bus (year offset, month, day, day of week, hour, minute, second) and raises an alarm when it reaches a programmed time. A 2-bit depth setting chooses how much of the date must agree. The shallowest depth looks only at the time of day. Each deeper setting adds the day, then the month, then the year. The day of week is carried on the bus but is never part of the comparison.

Software programs the alarm through a byte-wide write port. It reads back through an address-selected read port. Each time field is range-checked when written. An illegal value is dropped and raises a sticky error flag. The alarm flag is sticky and is cleared by writing a one to its bit. It is set once per match, on the cycle that follows the calendar second moving into the matching value. The interrupt output is the flag gated by an enable bit. A synchronous software reset returns all alarm and control state to its reset values.

Top module: `cal_alarm_cmp`

Register addresses: 0 second, 1 minute, 2 hour, 3 day of month, 4 month, 5 year offset, 6 control, 7 status. Control bit 0 is the interrupt enable and control bits 2:1 are the match depth. Status bit 0 is the alarm flag and status bit 1 is the range error. Both status bits are cleared by writing 1.

## Requirements
- R1: After rst_n, alarm_flag, alarm_irq and range_err are 0, and every alarm register (addresses 0–6) reads 0, which also puts the match depth at 0 and the enable at 0.
- R2: At depth 0 (control bits 2:1 = 0), a match needs only second, minute and hour equal. Day, month and year differences do not prevent it.
- R3: Depth 1 also needs the day equal, depth 2 also needs day and month equal, and depth 3 also needs day, month and year equal.
- R4: The day-of-week input never affects matching. A match fires for any cal_wday value.
- R5: A write is rejected when it is outside these ranges: second above 59, minute above 59, hour above 23, day of 0 or above 31, month of 0 or above 12. A rejected write leaves the register unchanged and sets range_err one cycle later.
- R6: alarm_flag is set only in the cycle after cal_sec changes to a value that, together with the other compared fields, matches the alarm. A match that persists without a second change, or that arises only because the alarm registers were rewritten, does not set it again.
- R7: alarm_irq equals alarm_flag ANDed with control bit 0, and follows a change of the enable bit without needing a new match.
- R8: Writing status with bit 0 set clears alarm_flag, and writing it with bit 1 set clears range_err. Otherwise both flags hold. A new match in the same cycle as a flag-clear write leaves the flag set.
- R9: A one-cycle soft_rst clears all alarm registers, the control register, alarm_flag and range_err.
- R10: The year register holds the full 8-bit offset range 0 to 255 and never raises a range error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of alarm state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W (8) | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W (8) | Register read data (combinational) |
| cal_year | input | YEAR_W (8) | Calendar year offset |
| cal_month | input | 4 | Calendar month 1–12 |
| cal_day | input | 5 | Calendar day 1–31 |
| cal_wday | input | 3 | Calendar day of week (not compared) |
| cal_hour | input | 5 | Calendar hour 0–23 |
| cal_min | input | 6 | Calendar minute 0–59 |
| cal_sec | input | 6 | Calendar second 0–59 |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt (flag AND enable) |
| range_err | output | 1 | Sticky rejected-write flag |

## Verification
The bench builds the block with its default widths: an 8-bit data bus and an 8-bit year. With these widths, the year limits 0 and 255 can be written and read back directly. The 8-bit bus can also carry the illegal values just past each legal range (60, 24, 13, 0), so every rejection edge is exercised. All four depths are then driven with one field at a time mismatched, which shows that each field joins the comparison at the right depth.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

   localparam int ADDR_W = 3;
   localparam int SEC_W  = 6;
   localparam int MIN_W  = 6;
   localparam int HOUR_W = 5;
   localparam int DAY_W  = 5;
   localparam int MON_W  = 4;
   localparam int WDAY_W = 3;

   localparam int SEC_MAX   = 59;
   localparam int MIN_MAX   = 59;
   localparam int HOUR_MAX  = 23;
   localparam int DAY_MAX   = 31;
   localparam int MONTH_MAX = 12;

   // Field order sets the depth at which each field joins the compare.
   localparam int NUM_FIELDS = 6;
   localparam int FLD_ALWAYS = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_SEC   = 3'd0,
      REG_MIN   = 3'd1,
      REG_HOUR  = 3'd2,
      REG_DAY   = 3'd3,
      REG_MONTH = 3'd4,
      REG_YEAR  = 3'd5,
      REG_CTRL  = 3'd6,
      REG_STAT  = 3'd7
   } reg_sel_e;

   typedef enum logic [1:0] {
      LVL_TIME  = 2'd0,
      LVL_DAY   = 2'd1,
      LVL_MONTH = 2'd2,
      LVL_YEAR  = 2'd3
   } match_lvl_e;

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int YEAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SEC_W-1:0]  al_sec,
   output logic [MIN_W-1:0]  al_min,
   output logic [HOUR_W-1:0] al_hour,
   output logic [DAY_W-1:0]  al_day,
   output logic [MON_W-1:0]  al_month,
   output logic [YEAR_W-1:0] al_year,
   output logic              irq_en,
   output match_lvl_e        lvl,
   output logic              wr_bad,
   output logic              clr_flag,
   output logic              clr_err
);

   logic out_of_range;

   always_comb begin
      out_of_range = 1'b0;
      unique case (reg_sel_e'(wr_addr))
         REG_SEC:   out_of_range = (wr_data > DATA_W'(SEC_MAX));
         REG_MIN:   out_of_range = (wr_data > DATA_W'(MIN_MAX));
         REG_HOUR:  out_of_range = (wr_data > DATA_W'(HOUR_MAX));
         REG_DAY:   out_of_range = (wr_data == '0) || (wr_data > DATA_W'(DAY_MAX));
         REG_MONTH: out_of_range = (wr_data == '0) || (wr_data > DATA_W'(MONTH_MAX));
         default:   out_of_range = 1'b0;
      endcase
   end

   assign wr_bad   = wr_en && out_of_range;
   assign clr_flag = wr_en && (reg_sel_e'(wr_addr) == REG_STAT) && wr_data[0];
   assign clr_err  = wr_en && (reg_sel_e'(wr_addr) == REG_STAT) && wr_data[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_sec   <= '0;
         al_min   <= '0;
         al_hour  <= '0;
         al_day   <= '0;
         al_month <= '0;
         al_year  <= '0;
         irq_en   <= 1'b0;
         lvl      <= LVL_TIME;
      end else if (soft_rst) begin
         al_sec   <= '0;
         al_min   <= '0;
         al_hour  <= '0;
         al_day   <= '0;
         al_month <= '0;
         al_year  <= '0;
         irq_en   <= 1'b0;
         lvl      <= LVL_TIME;
      end else if (wr_en && !out_of_range) begin
         unique case (reg_sel_e'(wr_addr))
            REG_SEC:   al_sec   <= wr_data[SEC_W-1:0];
            REG_MIN:   al_min   <= wr_data[MIN_W-1:0];
            REG_HOUR:  al_hour  <= wr_data[HOUR_W-1:0];
            REG_DAY:   al_day   <= wr_data[DAY_W-1:0];
            REG_MONTH: al_month <= wr_data[MON_W-1:0];
            REG_YEAR:  al_year  <= wr_data[YEAR_W-1:0];
            REG_CTRL: begin
               irq_en <= wr_data[0];
               lvl    <= match_lvl_e'(wr_data[2:1]);
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int YEAR_W = 8
) (
   input  logic [SEC_W-1:0]  al_sec,
   input  logic [MIN_W-1:0]  al_min,
   input  logic [HOUR_W-1:0] al_hour,
   input  logic [DAY_W-1:0]  al_day,
   input  logic [MON_W-1:0]  al_month,
   input  logic [YEAR_W-1:0] al_year,
   input  logic [SEC_W-1:0]  cal_sec,
   input  logic [MIN_W-1:0]  cal_min,
   input  logic [HOUR_W-1:0] cal_hour,
   input  logic [DAY_W-1:0]  cal_day,
   input  logic [MON_W-1:0]  cal_month,
   input  logic [YEAR_W-1:0] cal_year,
   input  match_lvl_e        lvl,
   output logic              hit
);

   logic [DATA_W-1:0]     alm_f [NUM_FIELDS];
   logic [DATA_W-1:0]     cal_f [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] same;
   logic [NUM_FIELDS-1:0] needed;

   assign alm_f[0] = DATA_W'(al_sec);
   assign alm_f[1] = DATA_W'(al_min);
   assign alm_f[2] = DATA_W'(al_hour);
   assign alm_f[3] = DATA_W'(al_day);
   assign alm_f[4] = DATA_W'(al_month);
   assign alm_f[5] = DATA_W'(al_year);

   assign cal_f[0] = DATA_W'(cal_sec);
   assign cal_f[1] = DATA_W'(cal_min);
   assign cal_f[2] = DATA_W'(cal_hour);
   assign cal_f[3] = DATA_W'(cal_day);
   assign cal_f[4] = DATA_W'(cal_month);
   assign cal_f[5] = DATA_W'(cal_year);

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
      assign same[i] = (alm_f[i] == cal_f[i]);
      if (i < FLD_ALWAYS) begin : g_base
         assign needed[i] = 1'b1;
      end else begin : g_depth
         assign needed[i] = (lvl >= 2'(i - FLD_ALWAYS + 1));
      end
   end

   assign hit = &(same | ~needed);

endmodule

// File: rtl/alarm_event.sv
module alarm_event
   import cal_alarm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [SEC_W-1:0] cal_sec,
   input  logic             hit,
   input  logic             clr_flag,
   input  logic             wr_bad,
   input  logic             clr_err,
   input  logic             irq_en,
   output logic             flag,
   output logic             err,
   output logic             irq
);

   logic [SEC_W-1:0] last_sec;
   logic             primed;
   logic             sec_step;

   assign sec_step = primed && (cal_sec != last_sec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_sec <= '0;
         primed   <= 1'b0;
         flag     <= 1'b0;
         err      <= 1'b0;
      end else begin
         last_sec <= cal_sec;
         primed   <= 1'b1;
         if (soft_rst) begin
            flag <= 1'b0;
            err  <= 1'b0;
         end else begin
            if (sec_step && hit) flag <= 1'b1;
            else if (clr_flag)   flag <= 1'b0;
            if (wr_bad)          err  <= 1'b1;
            else if (clr_err)    err  <= 1'b0;
         end
      end
   end

   assign irq = flag & irq_en;

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int YEAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [YEAR_W-1:0] cal_year,
   input  logic [MON_W-1:0]  cal_month,
   input  logic [DAY_W-1:0]  cal_day,
   input  logic [WDAY_W-1:0] cal_wday,
   input  logic [HOUR_W-1:0] cal_hour,
   input  logic [MIN_W-1:0]  cal_min,
   input  logic [SEC_W-1:0]  cal_sec,
   output logic              alarm_flag,
   output logic              alarm_irq,
   output logic              range_err
);

   if (DATA_W < YEAR_W) begin : g_chk_year
      $error("DATA_W must be at least YEAR_W");
   end
   if (DATA_W < SEC_W) begin : g_chk_data
      $error("DATA_W must hold the widest time field");
   end

   logic [SEC_W-1:0]  al_sec;
   logic [MIN_W-1:0]  al_min;
   logic [HOUR_W-1:0] al_hour;
   logic [DAY_W-1:0]  al_day;
   logic [MON_W-1:0]  al_month;
   logic [YEAR_W-1:0] al_year;
   logic              irq_en;
   match_lvl_e        lvl;
   logic              wr_bad, clr_flag, clr_err, hit;

   // Weekday is carried on the bus but takes no part in matching.
   logic unused_wday;
   assign unused_wday = ^cal_wday;

   alarm_regs #(.DATA_W(DATA_W), .YEAR_W(YEAR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
      .al_day(al_day), .al_month(al_month), .al_year(al_year),
      .irq_en(irq_en), .lvl(lvl),
      .wr_bad(wr_bad), .clr_flag(clr_flag), .clr_err(clr_err)
   );

   alarm_match #(.DATA_W(DATA_W), .YEAR_W(YEAR_W)) u_match (
      .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
      .al_day(al_day), .al_month(al_month), .al_year(al_year),
      .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
      .cal_day(cal_day), .cal_month(cal_month), .cal_year(cal_year),
      .lvl(lvl), .hit(hit)
   );

   alarm_event u_event (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .cal_sec(cal_sec), .hit(hit),
      .clr_flag(clr_flag), .wr_bad(wr_bad), .clr_err(clr_err),
      .irq_en(irq_en),
      .flag(alarm_flag), .err(range_err), .irq(alarm_irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(rd_addr))
         REG_SEC:   rd_data = DATA_W'(al_sec);
         REG_MIN:   rd_data = DATA_W'(al_min);
         REG_HOUR:  rd_data = DATA_W'(al_hour);
         REG_DAY:   rd_data = DATA_W'(al_day);
         REG_MONTH: rd_data = DATA_W'(al_month);
         REG_YEAR:  rd_data = DATA_W'(al_year);
         REG_CTRL:  rd_data = DATA_W'({lvl, irq_en});
         REG_STAT:  rd_data = DATA_W'({range_err, alarm_flag});
         default:   rd_data = '0;
      endcase
   end

endmodule

// File: rtl/cal_alarm_cmp_chk.sv
module cal_alarm_cmp_chk
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [SEC_W-1:0]  cal_sec,
   input logic              alarm_flag,
   input logic              alarm_irq,
   input logic              range_err
);

   logic flag_clr_wr;
   assign flag_clr_wr = wr_en && (wr_addr == REG_STAT) && wr_data[0];

   // R6: a rising flag is always preceded by a change of the calendar second
   a_r6_flag_needs_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> ($past(cal_sec) != $past(cal_sec, 2)));

   // R7: interrupt never without the flag
   a_r7_irq_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> alarm_flag);

   // R8: flag holds unless cleared
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !flag_clr_wr && !soft_rst) |=> alarm_flag);

   // R5: an out-of-range month write raises the error flag
   a_r5_bad_month_err: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !soft_rst && (wr_addr == REG_MONTH) &&
       ((wr_data == '0) || (wr_data > DATA_W'(MONTH_MAX)))) |=> range_err);

   // R9: software reset clears all flags
   a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!alarm_flag && !alarm_irq && !range_err));

endmodule

bind cal_alarm_cmp cal_alarm_cmp_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .cal_sec(cal_sec), .alarm_flag(alarm_flag),
   .alarm_irq(alarm_irq), .range_err(range_err)
);

// File: tb/cal_alarm_cmp_bench.sv
module cal_alarm_cmp_bench;
   import cal_alarm_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic [7:0]  cal_year = 8'd0;
   logic [3:0]  cal_month = 4'd9;
   logic [4:0]  cal_day = 5'd1;
   logic [2:0]  cal_wday = 3'd2;
   logic [4:0]  cal_hour = 5'd5;
   logic [5:0]  cal_min = 6'd20;
   logic [5:0]  cal_sec = 6'd0;
   logic        alarm_flag, alarm_irq, range_err;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cal_alarm_cmp u_cal_alarm_cmp (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .cal_year(cal_year), .cal_month(cal_month), .cal_day(cal_day),
      .cal_wday(cal_wday), .cal_hour(cal_hour), .cal_min(cal_min),
      .cal_sec(cal_sec),
      .alarm_flag(alarm_flag), .alarm_irq(alarm_irq), .range_err(range_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic step_sec(input logic [5:0] s);
      @(negedge clk);
      cal_sec = s;
      @(negedge clk);
   endtask

   task automatic fire(input string tag, input logic exp);
      step_sec(6'd9);
      step_sec(6'd10);
      chk(tag, alarm_flag, exp);
   endtask

   task automatic clear_flag;
      wr(REG_STAT, 8'h01);
   endtask

   task automatic t_reset;
      chk("R1 flag after reset", alarm_flag, 1'b0);
      chk("R1 irq after reset", alarm_irq, 1'b0);
      chk("R1 err after reset", range_err, 1'b0);
      rd_chk(REG_CTRL, 8'h00, "R1 ctrl after reset");
      rd_chk(REG_SEC, 8'h00, "R1 sec after reset");
   endtask

   task automatic t_level0;
      wr(REG_SEC, 8'd10); wr(REG_MIN, 8'd20); wr(REG_HOUR, 8'd5);
      wr(REG_DAY, 8'd7); wr(REG_MONTH, 8'd3); wr(REG_YEAR, 8'd40);
      wr(REG_CTRL, 8'h01);
      step_sec(6'd9);
      chk("R2 no flag before match", alarm_flag, 1'b0);
      step_sec(6'd10);
      chk("R2 depth0 flag", alarm_flag, 1'b1);
      chk("R7 irq with enable", alarm_irq, 1'b1);
      clear_flag();
      chk("R8 w1c flag", alarm_flag, 1'b0);
   endtask

   task automatic t_levels;
      wr(REG_CTRL, 8'h03);
      fire("R3 depth1 day mismatch", 1'b0);
      @(negedge clk); cal_day = 5'd7;
      fire("R3 depth1 day match", 1'b1);
      clear_flag();
      wr(REG_CTRL, 8'h05);
      fire("R3 depth2 month mismatch", 1'b0);
      @(negedge clk); cal_month = 4'd3;
      fire("R3 depth2 month match", 1'b1);
      clear_flag();
      wr(REG_CTRL, 8'h07);
      fire("R3 depth3 year mismatch", 1'b0);
      @(negedge clk); cal_year = 8'd40;
      fire("R3 depth3 year match", 1'b1);
      clear_flag();
   endtask

   task automatic t_wday;
      @(negedge clk); cal_wday = 3'd6;
      fire("R4 weekday 6", 1'b1);
      clear_flag();
      @(negedge clk); cal_wday = 3'd0;
      fire("R4 weekday 0", 1'b1);
      clear_flag();
   endtask

   task automatic t_oneshot;
      fire("R6 fires on step", 1'b1);
      clear_flag();
      repeat (5) @(negedge clk);
      chk("R6 no refire while held", alarm_flag, 1'b0);
      step_sec(6'd11);
      wr(REG_SEC, 8'd11);
      repeat (3) @(negedge clk);
      chk("R6 no fire on alarm rewrite", alarm_flag, 1'b0);
      wr(REG_SEC, 8'd10);
   endtask

   task automatic t_irq;
      wr(REG_CTRL, 8'h06);
      fire("R7 flag with enable off", 1'b1);
      chk("R7 irq gated off", alarm_irq, 1'b0);
      wr(REG_CTRL, 8'h07);
      chk("R7 irq after enable", alarm_irq, 1'b1);
      clear_flag();
      chk("R7 irq after clear", alarm_irq, 1'b0);
   endtask

   task automatic t_set_wins;
      step_sec(6'd9);
      @(negedge clk);
      cal_sec = 6'd10;
      wr_en = 1'b1; wr_addr = REG_STAT; wr_data = 8'h01;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R8 set beats clear", alarm_flag, 1'b1);
      clear_flag();
      chk("R8 cleared after", alarm_flag, 1'b0);
   endtask

   task automatic t_range;
      wr(REG_MONTH, 8'd13);
      chk("R5 month 13 err", range_err, 1'b1);
      rd_chk(REG_MONTH, 8'd3, "R5 month kept");
      wr(REG_STAT, 8'h02);
      chk("R8 w1c err", range_err, 1'b0);
      wr(REG_DAY, 8'd0);
      chk("R5 day 0 err", range_err, 1'b1);
      rd_chk(REG_DAY, 8'd7, "R5 day kept");
      wr(REG_STAT, 8'h02);
      wr(REG_HOUR, 8'd24);
      chk("R5 hour 24 err", range_err, 1'b1);
      wr(REG_STAT, 8'h02);
      wr(REG_SEC, 8'd60);
      chk("R5 sec 60 err", range_err, 1'b1);
      rd_chk(REG_SEC, 8'd10, "R5 sec kept");
      wr(REG_STAT, 8'h02);
      wr(REG_MIN, 8'd59);
      chk("R5 min 59 accepted", range_err, 1'b0);
      rd_chk(REG_MIN, 8'd59, "R5 min 59 stored");
      wr(REG_MIN, 8'd20);
   endtask

   task automatic t_year;
      wr(REG_YEAR, 8'd255);
      chk("R10 year 255 no err", range_err, 1'b0);
      rd_chk(REG_YEAR, 8'd255, "R10 year 255 stored");
      wr(REG_YEAR, 8'd0);
      rd_chk(REG_YEAR, 8'd0, "R10 year 0 stored");
      wr(REG_YEAR, 8'd40);
   endtask

   task automatic t_soft;
      fire("R9 flag before soft reset", 1'b1);
      wr(REG_MONTH, 8'd0);
      chk("R9 err before soft reset", range_err, 1'b1);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      chk("R9 flag cleared", alarm_flag, 1'b0);
      chk("R9 err cleared", range_err, 1'b0);
      chk("R9 irq cleared", alarm_irq, 1'b0);
      rd_chk(REG_CTRL, 8'h00, "R9 ctrl cleared");
      rd_chk(REG_SEC, 8'h00, "R9 sec cleared");
      rd_chk(REG_MONTH, 8'h00, "R9 month cleared");
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level0();
      t_levels();
      t_wday();
      t_oneshot();
      t_irq();
      t_set_wins();
      t_range();
      t_year();
      t_soft();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule